// File: doc/BRIEF.md
# Shared Cell Bus Output Framer

This block controls the output side of one switching-memory device whose cell output bus is shared with other identical devices. All devices watch a common frame line. A pulse on that line marks the start of a cell. Every device, the sender included, restarts its nibble counter from that pulse. The counters therefore stay in step, and each device knows when the bus is free again.

An external controller asks for a dispatch with a one-cycle request. When the bus is idle, the block drives a one-cycle frame pulse. It then walks the read address of its output cell buffer from the start address to the stop address, one nibble per clock, and marks each nibble valid. If the request arrives while any device is sending, it is held in a one-deep pending flag until the shared counter reaches the stop address. A frame pulse from another device that arrives just as this device is about to launch also makes it hold. The frame line is released whenever no pulse is being driven.

Top module: `shared_cell_bus_framer`

## Requirements
- R1: A synchronous reset releases the frame line (`frm_oe` = 0), clears `nib_valid` and `req_overrun`, parks `buf_addr` at `cfg_stop`, and drops any pending request, so no frame follows the reset.
- R2: At every rising edge where `frm_in` is sampled high, whichever device drives it, `buf_addr` is loaded with `cfg_start`.
- R3: At each rising edge with `frm_in` low, `buf_addr` advances by one while it differs from `cfg_stop`, and stays at `cfg_stop` once it gets there.
- R4: A request sampled at an edge while the bus is idle makes `frm_oe` and `frm_out` high in the cycle after the next rising edge. The pulse lasts exactly one cycle.
- R5: In the cycle after its own frame pulse the block raises `nib_valid` with `buf_addr` = `cfg_start`. It presents consecutive addresses up to `cfg_stop`, one per cycle, which is `cfg_stop - cfg_start + 1` nibbles, and then drops `nib_valid`.
- R6: A request made while the shared counter is below `cfg_stop` is held. The frame pulse appears in the cycle after the first edge that samples the counter at `cfg_stop`.
- R7: If `frm_in` is sampled high from another device at the edge where a launch would occur, the block does not drive its pulse. It waits for the counter to reach `cfg_stop` again.
- R8: `frm_oe` is low in every cycle other than the one-cycle frame pulse.
- R9: A request while one is already pending is ignored: only one cell is sent. It sets `req_overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | One-cycle dispatch request from the controller |
| cfg_start | input | ADDR_W | First nibble address of a cell, same on all devices |
| cfg_stop | input | ADDR_W | Last nibble address of a cell, at least `cfg_start` |
| frm_in | input | 1 | Sampled state of the shared frame line |
| frm_oe | output | 1 | Enable for the frame line pad driver |
| frm_out | output | 1 | Value driven on the frame line when enabled |
| buf_addr | output | ADDR_W | Nibble read address into the output cell buffer, which is also the shared counter |
| nib_valid | output | 1 | This device's nibble is on the bus this cycle |
| req_overrun | output | 1 | Sticky flag: a request arrived while one was pending |

## Verification
The bench builds the block with a 6-bit nibble address. It first configures an eight-nibble cell (start 2, stop 9), then resets into a one-nibble cell (start and stop both 5). The longer cell leaves room to place requests and foreign frame pulses at chosen offsets inside another device's cell, which exercises holding, the collision-avoidance hold and overrun. The one-nibble case reaches the corner where the counter loads directly onto the stop address. A modelled second device drives the frame line alongside the block's own pulse.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    // Dispatch phase of one device on the shared bus
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FRAME = 2'd1,
        PH_SEND  = 2'd2
    } phase_e;

    // Bundle handed from the dispatch controller to the top
    typedef struct packed {
        logic drive;    // frame pulse this cycle
        logic sending;  // own nibble on the bus this cycle
        logic overrun;  // sticky lost-request flag
    } disp_out_t;

    // Launch allowed only with a held request, a quiet counter and no foreign pulse
    function automatic logic may_launch(input logic pending,
                                        input logic bus_idle,
                                        input logic frame_seen);
        return pending && bus_idle && !frame_seen;
    endfunction

endpackage

// File: rtl/cbf_nibble_counter.sv
module cbf_nibble_counter #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_seen,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] stop_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              at_stop
);

    assign at_stop = (addr == stop_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= stop_addr;
        end else if (frm_seen) begin
            addr <= start_addr;
        end else if (!at_stop) begin
            addr <= addr + 1'b1;
        end
    end

    // R2: any sampled frame pulse realigns the counter to the start address
    p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
        frm_seen |=> (addr == $past(start_addr)));

    // R3: parked counter stays parked without a pulse
    p_park_r3: assert property (@(posedge clk) disable iff (rst)
        (!frm_seen && at_stop) |=> $stable(addr));

endmodule

// File: rtl/cbf_dispatch.sv
module cbf_dispatch
    import cbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ld_req,
    input  logic      frm_seen,
    input  logic      bus_idle,
    output disp_out_t dout
);

    phase_e phase, phase_nx;
    logic   pending;
    logic   overrun;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: begin
                if (may_launch(pending, bus_idle, frm_seen))
                    phase_nx = PH_FRAME;
            end
            PH_FRAME: begin
                phase_nx = frm_seen ? PH_SEND : PH_IDLE;
            end
            PH_SEND: begin
                if (frm_seen || bus_idle)
                    phase_nx = PH_IDLE;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            phase <= phase_nx;
            if (ld_req && pending)
                overrun <= 1'b1;
            if (phase == PH_FRAME && frm_seen)
                pending <= 1'b0;
            else if (ld_req)
                pending <= 1'b1;
        end
    end

    assign dout.drive   = (phase == PH_FRAME);
    assign dout.sending = (phase == PH_SEND);
    assign dout.overrun = overrun;

    // R7: a foreign pulse at the launch edge blocks the launch
    p_hold_on_peer_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && frm_seen) |=> (phase != PH_FRAME));

    // R6: never launch while the shared counter is mid-cell
    p_launch_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !bus_idle) |=> (phase != PH_FRAME));

    // R9: lost-request flag is sticky
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/shared_cell_bus_framer.sv
module shared_cell_bus_framer
    import cbf_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_stop,
    input  logic              frm_in,
    output logic              frm_oe,
    output logic              frm_out,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              nib_valid,
    output logic              req_overrun
);

    logic      at_stop;
    disp_out_t dout;

    cbf_nibble_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .frm_seen   (frm_in),
        .start_addr (cfg_start),
        .stop_addr  (cfg_stop),
        .addr       (buf_addr),
        .at_stop    (at_stop)
    );

    cbf_dispatch u_disp (
        .clk      (clk),
        .rst      (rst),
        .ld_req   (ld_req),
        .frm_seen (frm_in),
        .bus_idle (at_stop),
        .dout     (dout)
    );

    assign frm_oe      = dout.drive;
    assign frm_out     = dout.drive;
    assign nib_valid   = dout.sending;
    assign req_overrun = dout.overrun;

    // R4, R8: frame pulse is a single cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        frm_oe |=> !frm_oe);

    // R5: first nibble at the start address right after the own pulse
    p_first_nibble_r5: assert property (@(posedge clk) disable iff (rst)
        (frm_oe && frm_in) |=> (nib_valid && buf_addr == $past(cfg_start)));

    // R3: counter steps by one between pulses until parked
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!frm_in && buf_addr != cfg_stop) |=> (buf_addr == $past(buf_addr) + 1'b1));

endmodule

// File: tb/shared_cell_bus_framer_tb.sv
`timescale 1ns/1ps
module shared_cell_bus_framer_tb;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_req = 1'b0;
    logic [AW-1:0] cfg_start = 6'd2;
    logic [AW-1:0] cfg_stop  = 6'd9;
    logic          peer_frm = 1'b0;
    logic          frm_in;
    logic          frm_oe, frm_out, nib_valid, req_overrun;
    logic [AW-1:0] buf_addr;

    int n_chk = 0;
    int n_fail = 0;
    int frames = 0;
    bit done = 1'b0;
    bit prev_oe = 1'b0;
    logic [AW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    // Shared frame line: own drive plus a modelled peer device
    assign frm_in = (frm_oe & frm_out) | peer_frm;

    shared_cell_bus_framer #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ld_req(ld_req),
        .cfg_start(cfg_start), .cfg_stop(cfg_stop), .frm_in(frm_in),
        .frm_oe(frm_oe), .frm_out(frm_out), .buf_addr(buf_addr),
        .nib_valid(nib_valid), .req_overrun(req_overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push_cell(input int s, input int e);
        for (int a = s; a <= e; a++) exp_q.push_back(a[AW-1:0]);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            prev_oe <= 1'b0;
        end else begin
            if (frm_oe) frames <= frames + 1;
            if (frm_oe && prev_oe)
                chk(1'b0, "R4 pulse longer than one cycle", 2, 1);
            if (prev_oe)
                chk(nib_valid, "R5 nibble after pulse", nib_valid, 1);
            if (nib_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected nibble addr", buf_addr, 0);
                end else begin
                    logic [AW-1:0] e;
                    e = exp_q.pop_front();
                    chk(buf_addr == e, "R5 nibble addr", buf_addr, e);
                end
            end
            prev_oe <= frm_oe;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end

    initial begin
        int f0;
        bit any_oe;
        localparam int L = 8;

        // R1: reset state
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(frm_oe == 0, "R1 frm_oe after reset", frm_oe, 0);
        chk(nib_valid == 0, "R1 nib_valid after reset", nib_valid, 0);
        chk(buf_addr == 9, "R1 buf_addr parked", buf_addr, 9);
        chk(req_overrun == 0, "R1 overrun clear", req_overrun, 0);
        repeat (3) tick();

        // R4 R5: request on idle bus
        push_cell(2, 9);
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        chk(frm_oe == 0, "R4 no pulse after first edge", frm_oe, 0);
        tick();
        chk(frm_oe == 1 && frm_out == 1, "R4 pulse after second edge", frm_oe, 1);
        tick();
        chk(frm_oe == 0, "R8 released after pulse", frm_oe, 0);
        chk(buf_addr == 2, "R2 own pulse loads start", buf_addr, 2);
        repeat (L + 2) tick();
        chk(buf_addr == 9 && nib_valid == 0, "R3 parked after cell", buf_addr, 9);
        repeat (4) tick();
        chk(buf_addr == 9, "R3 stays parked", buf_addr, 9);

        // R6: request during a peer cell
        peer_frm = 1'b1;
        tick();
        peer_frm = 1'b0;
        chk(buf_addr == 2 && nib_valid == 0, "R2 peer pulse loads start", buf_addr, 2);
        push_cell(2, 9);
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        chk(buf_addr == 3, "R3 counter steps", buf_addr, 3);
        any_oe = 1'b0;
        for (int k = 2; k < L; k++) begin
            tick();
            if (frm_oe) any_oe = 1'b1;
        end
        chk(!any_oe, "R6 held during peer cell", any_oe, 0);
        tick();
        chk(frm_oe == 1, "R6 pulse once parked", frm_oe, 1);
        repeat (L + 4) tick();

        // R7: peer pulse at the launch edge
        push_cell(2, 9);
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        peer_frm = 1'b1;
        tick();
        peer_frm = 1'b0;
        chk(frm_oe == 0, "R7 no pulse on collision", frm_oe, 0);
        chk(buf_addr == 2, "R7 realigned to peer", buf_addr, 2);
        any_oe = 1'b0;
        for (int k = 1; k < L; k++) begin
            tick();
            if (frm_oe) any_oe = 1'b1;
        end
        chk(!any_oe, "R7 held for peer cell", any_oe, 0);
        tick();
        chk(frm_oe == 1, "R7 pulse after peer cell", frm_oe, 1);
        repeat (L + 4) tick();

        // R9: double request while pending
        f0 = frames;
        peer_frm = 1'b1;
        tick();
        peer_frm = 1'b0;
        push_cell(2, 9);
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        chk(req_overrun == 0, "R9 no overrun on first request", req_overrun, 0);
        tick();
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        chk(req_overrun == 1, "R9 overrun raised", req_overrun, 1);
        repeat (3 * L) tick();
        chk(frames - f0 == 1, "R9 second request ignored", frames - f0, 1);
        chk(req_overrun == 1, "R9 overrun sticky", req_overrun, 1);

        // R1: reset drops a pending request
        peer_frm = 1'b1;
        tick();
        peer_frm = 1'b0;
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        f0 = frames;
        tick();
        chk(req_overrun == 0, "R1 overrun cleared", req_overrun, 0);
        chk(buf_addr == 9 && frm_oe == 0, "R1 parked after reset", buf_addr, 9);
        repeat (2 * L) tick();
        chk(frames == f0, "R1 pending dropped", frames - f0, 0);

        // R5: one-nibble cell
        rst = 1'b1;
        cfg_start = 6'd5;
        cfg_stop = 6'd5;
        repeat (2) tick();
        rst = 1'b0;
        tick();
        chk(buf_addr == 5, "R1 parked at new stop", buf_addr, 5);
        push_cell(5, 5);
        ld_req = 1'b1;
        tick();
        ld_req = 1'b0;
        tick();
        chk(frm_oe == 1, "R4 pulse single nibble", frm_oe, 1);
        tick();
        chk(nib_valid == 1 && buf_addr == 5, "R5 single nibble", buf_addr, 5);
        tick();
        chk(nib_valid == 0, "R5 single nibble ends", nib_valid, 0);
        repeat (4) tick();

        chk(exp_q.size() == 0, "R5 all expected nibbles seen", exp_q.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule